// File: doc/BRIEF.md
# Front-Panel LED Pattern Sequencer

This block drives a six-LED front-panel display from one of eight selectable display modes. A single push-button input steps through the modes. The button is synchronised, debounced, and acted on at the moment it is pressed in. One shared prescaler produces a slow step of about 2 Hz from the 40 MHz clock. That step advances a free-running count, two walking lights that turn in opposite directions, and a whole-display blink.

One mode is a status view. It shows an external clock level and three stretched event indicators, so that short events stay visible: a one-pulse-per-second strobe, activity on a serial receive line, and a bus acknowledge strobe. The last three modes show slices of a 16-bit output register.

The LED vector is indexed 5 down to 0 and has a fixed physical layout:

| LED bit | Position |
| --- | --- |
| led[5] | top-left |
| led[4] | top-middle |
| led[3] | top-right |
| led[2] | bottom-left |
| led[1] | bottom-middle |
| led[0] | bottom-right |

The pps, rx_line, ack_strobe and out_reg inputs are synchronous to clk. The ext_clk_lvl and button inputs are asynchronous.

Top module: `panel_led_sequencer`

## Requirements
- R1: After reset the selection is mode 1, and the step count, blink state and stretchers are all cleared, so led reads 6'b000000.
- R2: A debounced press (0 to 1) advances the selection by exactly one mode. A debounced release leaves the selection unchanged.
- R3: A press while mode 8 is selected returns the selection to mode 1.
- R4: After a two-flop synchroniser, a new button level is accepted only after it has differed from the accepted level on DEBOUNCE_CYCLES consecutive clocks. A shorter excursion has no effect on the selection.
- R5: Mode 1 shows the low six bits of a count that starts at 0 and increments once every STEP_DIV clocks.
- R6: Mode 2 lights exactly one LED. The lit LED starts at led[0] and moves one place toward the higher index on each step, wrapping from led[5] to led[0].
- R7: Mode 3 lights exactly one LED. The lit LED starts at led[0] and moves one place toward the lower index on each step, wrapping from led[0] to led[5].
- R8: Mode 4 drives all six LEDs to one common level. That level starts off and inverts on each step.
- R9: Mode 5 drives the LEDs as follows:
  - led[3] shows ext_clk_lvl, delayed by two synchroniser flops.
  - led[0] shows the one-per-second stretcher.
  - led[1] shows the receive-activity stretcher.
  - led[5] shows the acknowledge stretcher.
  - led[4] and led[2] are off.
- R10: Each stretcher triggers on a clock where its input shows its active edge: rising for pps and ack_strobe, falling for rx_line. Its output is high on the STRETCH_CYCLES clocks that follow the trigger. A new trigger restarts the full length.
- R11: Mode 6 shows out_reg[5:0] and mode 7 shows out_reg[11:6], in each case with the MSB of the slice on led[5].
- R12: Mode 8 shows out_reg[15:12] on led[3:0] and holds led[5:4] off.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | 40 MHz system clock |
| rst | input | 1 | Active-high asynchronous reset |
| button | input | 1 | Raw push-button level, high when pressed |
| ext_clk_lvl | input | 1 | External clock level to display |
| pps | input | 1 | One-pulse-per-second strobe |
| rx_line | input | 1 | Serial receive data, idle high |
| ack_strobe | input | 1 | Bus acknowledge strobe |
| out_reg | input | 16 | Output register value to display |
| led | output | 6 | Front-panel LED drive, high lights the LED |

## Verification
A corrupted selection appears on led at the very next clock, because the display is a pure function of the selection and of registered state. A wrong prescaler phase or step state appears at the first step boundary, as an early or late change in mode 1, 2, 3 or 4. A faulty debounce count or stretcher count first appears DEBOUNCE_CYCLES or STRETCH_CYCLES clocks after the stimulus, as a mode change or LED edge on the wrong cycle. The bench therefore compares led against a behavioural model on every clock, in every mode.

// File: rtl/led_seq_pkg.sv
package led_seq_pkg;
   localparam int LED_W   = 6;
   localparam int REG_W   = 16;
   localparam int NUM_PAT = 8;
   localparam int SEL_W   = $clog2(NUM_PAT);
   localparam int NUM_EV  = 3;

   // event slots in the stretcher bank
   localparam int EV_PPS = 0;
   localparam int EV_RX  = 1;
   localparam int EV_ACK = 2;
   // 1 = rising edge triggers, 0 = falling edge triggers
   localparam logic [NUM_EV-1:0] EV_RISE = 3'b101;

   typedef enum logic [SEL_W-1:0] {
      PAT_COUNT  = 3'd0,
      PAT_CCW    = 3'd1,
      PAT_CW     = 3'd2,
      PAT_BLINK  = 3'd3,
      PAT_STATUS = 3'd4,
      PAT_LOW    = 3'd5,
      PAT_MID    = 3'd6,
      PAT_HIGH   = 3'd7
   } pat_e;
endpackage

// File: rtl/led_seq_prescaler.sv
module led_seq_prescaler #(
   parameter int STEP_DIV = 16777216
) (
   input  logic                          clk,
   input  logic                          rst,
   output logic [led_seq_pkg::LED_W-1:0] slow_cnt,
   output logic [led_seq_pkg::LED_W-1:0] walk_up,
   output logic [led_seq_pkg::LED_W-1:0] walk_dn,
   output logic                          blink
);
   import led_seq_pkg::*;
   localparam int DIV_W = $clog2(STEP_DIV);

   generate
      if (STEP_DIV < 2) begin : g_bad_div
         $error("STEP_DIV must be at least 2");
      end
   endgenerate

   logic [DIV_W-1:0] div_q;
   logic             step;

   assign step = (div_q == DIV_W'(STEP_DIV - 1));

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         div_q    <= '0;
         slow_cnt <= '0;
         walk_up  <= LED_W'(1);
         walk_dn  <= LED_W'(1);
         blink    <= 1'b0;
      end else begin
         div_q <= step ? '0 : div_q + 1'b1;
         if (step) begin
            slow_cnt <= slow_cnt + 1'b1;
            walk_up  <= {walk_up[LED_W-2:0], walk_up[LED_W-1]};
            walk_dn  <= {walk_dn[0], walk_dn[LED_W-1:1]};
            blink    <= ~blink;
         end
      end
   end

   // R5
   count_step_chk: assert property (@(posedge clk) disable iff (rst)
      step |=> slow_cnt == $past(slow_cnt) + 1'b1);
   // R6
   walk_up_onehot_chk: assert property (@(posedge clk) disable iff (rst)
      $countones(walk_up) == 1);
   // R7
   walk_dn_onehot_chk: assert property (@(posedge clk) disable iff (rst)
      $countones(walk_dn) == 1);
   // R8
   blink_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !step |=> $stable(blink));
endmodule

// File: rtl/led_seq_debounce.sv
module led_seq_debounce #(
   parameter int DEBOUNCE_CYCLES = 400000
) (
   input  logic clk,
   input  logic rst,
   input  logic raw,
   output logic press
);
   localparam int CNT_W = $clog2(DEBOUNCE_CYCLES);

   generate
      if (DEBOUNCE_CYCLES < 2) begin : g_bad_db
         $error("DEBOUNCE_CYCLES must be at least 2");
      end
   endgenerate

   logic             sync1, sync2, level;
   logic [CNT_W-1:0] cnt;
   logic             done;

   assign done  = (cnt == CNT_W'(DEBOUNCE_CYCLES - 1));
   assign press = sync2 & ~level & done;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         sync1 <= 1'b0;
         sync2 <= 1'b0;
         level <= 1'b0;
         cnt   <= '0;
      end else begin
         sync1 <= raw;
         sync2 <= sync1;
         if (sync2 != level) begin
            if (done) begin
               level <= sync2;
               cnt   <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end else begin
            cnt <= '0;
         end
      end
   end

   // R2
   press_single_chk: assert property (@(posedge clk) disable iff (rst)
      press |=> !press);
   // R4
   level_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (sync2 == level) |=> $stable(level));
endmodule

// File: rtl/led_seq_stretch.sv
module led_seq_stretch #(
   parameter int   STRETCH_CYCLES = 4000000,
   parameter logic RISE           = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic sig,
   output logic lit
);
   localparam int CNT_W = $clog2(STRETCH_CYCLES + 1);

   generate
      if (STRETCH_CYCLES < 1) begin : g_bad_len
         $error("STRETCH_CYCLES must be at least 1");
      end
   endgenerate

   logic             prev;
   logic             trig;
   logic [CNT_W-1:0] cnt;

   generate
      if (RISE) begin : g_rise
         assign trig = sig & ~prev;
      end else begin : g_fall
         assign trig = ~sig & prev;
      end
   endgenerate

   assign lit = (cnt != '0);

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         prev <= ~RISE;
         cnt  <= '0;
      end else begin
         prev <= sig;
         if (trig)
            cnt <= CNT_W'(STRETCH_CYCLES);
         else if (cnt != '0)
            cnt <= cnt - 1'b1;
      end
   end

   // R10
   stretch_start_chk: assert property (@(posedge clk) disable iff (rst)
      trig |=> lit);
   // R10
   stretch_full_chk: assert property (@(posedge clk) disable iff (rst)
      trig |=> cnt == CNT_W'(STRETCH_CYCLES));
endmodule

// File: rtl/panel_led_sequencer.sv
module panel_led_sequencer #(
   parameter int STEP_DIV        = 16777216,
   parameter int DEBOUNCE_CYCLES = 400000,
   parameter int STRETCH_CYCLES  = 4000000
) (
   input  logic        clk,
   input  logic        rst,
   input  logic        button,
   input  logic        ext_clk_lvl,
   input  logic        pps,
   input  logic        rx_line,
   input  logic        ack_strobe,
   input  logic [15:0] out_reg,
   output logic [5:0]  led
);
   import led_seq_pkg::*;

   logic [LED_W-1:0]  slow_cnt, walk_up, walk_dn;
   logic              blink, press;
   logic [NUM_EV-1:0] ev_in, ev_lit;
   logic              ext_s1, ext_s2;
   pat_e              sel;

   led_seq_prescaler #(.STEP_DIV(STEP_DIV)) u_pre (
      .clk(clk), .rst(rst), .slow_cnt(slow_cnt), .walk_up(walk_up),
      .walk_dn(walk_dn), .blink(blink));

   led_seq_debounce #(.DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)) u_btn (
      .clk(clk), .rst(rst), .raw(button), .press(press));

   assign ev_in[EV_PPS] = pps;
   assign ev_in[EV_RX]  = rx_line;
   assign ev_in[EV_ACK] = ack_strobe;

   generate
      for (genvar i = 0; i < NUM_EV; i++) begin : g_ev
         led_seq_stretch #(.STRETCH_CYCLES(STRETCH_CYCLES), .RISE(EV_RISE[i])) u_str (
            .clk(clk), .rst(rst), .sig(ev_in[i]), .lit(ev_lit[i]));
      end
   endgenerate

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         ext_s1 <= 1'b0;
         ext_s2 <= 1'b0;
         sel    <= PAT_COUNT;
      end else begin
         ext_s1 <= ext_clk_lvl;
         ext_s2 <= ext_s1;
         if (press)
            sel <= (sel == PAT_HIGH) ? PAT_COUNT : pat_e'(sel + 1'b1);
      end
   end

   always_comb begin
      unique case (sel)
         PAT_COUNT:  led = slow_cnt;
         PAT_CCW:    led = walk_up;
         PAT_CW:     led = walk_dn;
         PAT_BLINK:  led = {LED_W{blink}};
         PAT_STATUS: led = {ev_lit[EV_ACK], 1'b0, ext_s2, 1'b0,
                            ev_lit[EV_RX], ev_lit[EV_PPS]};
         PAT_LOW:    led = out_reg[5:0];
         PAT_MID:    led = out_reg[11:6];
         PAT_HIGH:   led = {2'b00, out_reg[15:12]};
         default:    led = '0;
      endcase
   end

   // R3
   sel_wrap_chk: assert property (@(posedge clk) disable iff (rst)
      (press && sel == PAT_HIGH) |=> sel == PAT_COUNT);
   // R2
   sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !press |=> $stable(sel));
   // R12
   high_top_off_chk: assert property (@(posedge clk) disable iff (rst)
      (sel == PAT_HIGH) |-> led[5:4] == 2'b00);
   // R9
   status_gaps_chk: assert property (@(posedge clk) disable iff (rst)
      (sel == PAT_STATUS) |-> (led[4] == 1'b0 && led[2] == 1'b0));
endmodule

// File: tb/panel_led_sequencer_test.sv
`timescale 1ns/1ps
module panel_led_sequencer_test;
   localparam int DIV = 16;
   localparam int DB  = 8;
   localparam int STR = 20;

   logic        clk = 0, rst = 1, button = 0, ext_clk_lvl = 0;
   logic        pps = 0, rx_line = 1, ack_strobe = 0;
   logic [15:0] out_reg = 16'h0000;
   logic [5:0]  led;

   int checks = 0, fails = 0;
   bit done = 0;

   panel_led_sequencer #(.STEP_DIV(DIV), .DEBOUNCE_CYCLES(DB), .STRETCH_CYCLES(STR)) uut (
      .clk(clk), .rst(rst), .button(button), .ext_clk_lvl(ext_clk_lvl), .pps(pps),
      .rx_line(rx_line), .ack_strobe(ack_strobe), .out_reg(out_reg), .led(led));

   always #5 clk = ~clk;

   // behavioural reference model
   int m_div, m_slow, m_up, m_dn, m_sel, m_dbcnt;
   bit m_blink, m_db;
   bit btn_q[$];
   bit ext_q[$];
   bit ev_prev[3];
   int ev_cnt[3];

   task automatic model_reset();
      m_div = 0; m_slow = 0; m_up = 0; m_dn = 0; m_sel = 0; m_dbcnt = 0;
      m_blink = 0; m_db = 0;
      btn_q = '{0, 0}; ext_q = '{0, 0};
      ev_prev[0] = 0; ev_prev[1] = 1; ev_prev[2] = 0;
      for (int i = 0; i < 3; i++) ev_cnt[i] = 0;
   endtask

   initial model_reset();

   always @(posedge clk) begin
      if (rst) model_reset();
      else begin
         bit s2, cur[3], hit;
         s2 = btn_q[1];
         if (m_div == DIV - 1) begin
            m_div = 0; m_slow = (m_slow + 1) % 64;
            m_up = (m_up + 1) % 6; m_dn = (m_dn + 5) % 6; m_blink = !m_blink;
         end else m_div++;
         if (s2 != m_db) begin
            if (m_dbcnt == DB - 1) begin
               if (s2) m_sel = (m_sel + 1) % 8;
               m_db = s2; m_dbcnt = 0;
            end else m_dbcnt++;
         end else m_dbcnt = 0;
         btn_q = '{button, btn_q[0]};
         ext_q = '{ext_clk_lvl, ext_q[0]};
         cur[0] = pps; cur[1] = rx_line; cur[2] = ack_strobe;
         for (int i = 0; i < 3; i++) begin
            hit = (i == 1) ? (!cur[i] && ev_prev[i]) : (cur[i] && !ev_prev[i]);
            if (hit) ev_cnt[i] = STR;
            else if (ev_cnt[i] > 0) ev_cnt[i]--;
            ev_prev[i] = cur[i];
         end
      end
   end

   function automatic logic [5:0] model_led();
      case (m_sel)
         0: return 6'(m_slow);
         1: return 6'(1 << m_up);
         2: return 6'(1 << m_dn);
         3: return m_blink ? 6'h3F : 6'h00;
         4: return {ev_cnt[2] > 0, 1'b0, ext_q[1], 1'b0, ev_cnt[1] > 0, ev_cnt[0] > 0};
         5: return out_reg[5:0];
         6: return out_reg[11:6];
         default: return {2'b00, out_reg[15:12]};
      endcase
   endfunction

   function automatic string sel_req(int s);
      case (s)
         0: return "R5"; 1: return "R6"; 2: return "R7"; 3: return "R8";
         4: return "R9 R10"; 5: return "R11"; 6: return "R11"; default: return "R12";
      endcase
   endfunction

   task automatic check(string req, logic [5:0] act, logic [5:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: led=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   // per-clock comparison against the model, away from the active edge
   always @(negedge clk) if (!rst && !done) check(sel_req(m_sel), led, model_led());

   task automatic wait_cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic press_btn();
      button = 1; wait_cyc(DB + 6);
      button = 0; wait_cyc(DB + 6);
   endtask

   initial begin
      wait_cyc(3);
      // R1: reset state
      check("R1", led, 6'b000000);
      rst = 0;
      wait_cyc(1);
      check("R1", led, 6'b000000);
      // R5: count in mode 1
      wait_cyc(DIV * 70);
      // R2: press to mode 2, then 3, then 4
      press_btn();  wait_cyc(DIV * 8);
      press_btn();  wait_cyc(DIV * 8);
      press_btn();  wait_cyc(DIV * 4);
      // R9 R10: status mode with events and retriggers
      press_btn();
      ext_clk_lvl = 1; wait_cyc(3);
      pps = 1; wait_cyc(2); pps = 0; wait_cyc(10);
      pps = 1; wait_cyc(1); pps = 0; wait_cyc(STR + 5);
      rx_line = 0; wait_cyc(4); rx_line = 1; wait_cyc(3); rx_line = 0; wait_cyc(1);
      rx_line = 1; wait_cyc(STR + 5);
      ack_strobe = 1; wait_cyc(1); ack_strobe = 0; ext_clk_lvl = 0; wait_cyc(STR + 5);
      // R11: mode 6 with known value
      out_reg = 16'hABCD;
      press_btn();
      check("R11", led, 6'h0D);
      out_reg = 16'h5A3C; wait_cyc(1);
      check("R11", led, 6'h3C);
      // R4: short glitch ignored
      button = 1; wait_cyc(DB - 2); button = 0; wait_cyc(DB + 6);
      check("R4", led, 6'h3C);
      press_btn();
      check("R11", led, 6'h28);
      press_btn();
      check("R12", led, 6'h05);
      out_reg = 16'hF000; wait_cyc(1);
      check("R12", led, 6'h0F);
      // R3: wrap back to mode 1
      press_btn();
      check("R3", led, 6'(model_led()));
      wait_cyc(DIV * 3);
      // R2: release with long hold leaves mode alone
      button = 1; wait_cyc(DB * 4); button = 0; wait_cyc(DB * 4);
      wait_cyc(DIV * 2);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #1000000;
      fails++;
      done = 1;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule